// File: doc/BRIEF.md
# Reservation Monitor for Load-Reserve / Store-Conditional

This block sits beside a plain memory array and decides, for each write, whether that write may go through. Requesting contexts make a reservation on an address granule by issuing a load-reserve. A later store-conditional from the same context is granted only if that reservation is still held. Any write to a granule, plain or conditional, removes every reservation on that granule, whatever context owns it. A context is identified by a CPU number together with a thread number.

The request port carries a strobe, an operation code, the context identity and a physical address. The address is reduced to its granule before it is stored or compared. In the same cycle as the strobe, the block drives a write grant, which the memory uses as its write enable, and a pass or fail status for conditional stores. The reservation table changes on the next rising clock edge. The table has a parameterized number of slots, and a full table makes room by evicting slot 0.

Top module: `resv_monitor`

## Requirements
- R1: A plain read (op code 0) leaves every reservation unchanged and drives no grant and no status.
- R2: Two addresses match exactly when they are equal after the low GRAN_LG bits are dropped; with the default GRAN_LG=3, 0x104 matches 0x100 and 0x108 does not.
- R3: A context holds at most one reservation. A load-reserve (op code 1) from a context that already holds one moves it to the new granule, so the old granule no longer succeeds.
- R4: Several contexts may hold reservations on the same granule at the same time.
- R5: Every write, plain store (op code 2) or store-conditional (op code 3), removes all reservations on the written granule for every context. A later conditional store to that granule then fails.
- R6: A plain store is always granted in its own cycle.
- R7: A store-conditional is granted only when its own context holds a reservation on the same granule. Otherwise wr_grant stays 0.
- R8: For a store-conditional, sc_valid is 1 and sc_status is 1 on success and 0 on failure. For any other operation both are 0.
- R9: When a new context reserves while every slot is valid, slot 0 is overwritten. A new context takes the lowest-index free slot when one exists.
- R10: The grant and status are combinational in the request cycle, and the table change takes effect at the next rising edge, so a conditional store in the cycle after its load-reserve succeeds.
- R11: A synchronous reset invalidates every reservation.
- R12: With req_valid low, wr_grant, sc_valid and sc_status are all 0 and the table does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 read, 1 load-reserve, 2 store, 3 store-conditional |
| req_cpu | input | CPU_W | CPU number of the requester |
| req_thr | input | THR_W | Thread number of the requester |
| req_addr | input | ADDR_W | Physical byte address |
| wr_grant | output | 1 | Write enable for the memory |
| sc_valid | output | 1 | Status below is meaningful (store-conditional cycle) |
| sc_status | output | 1 | 1 = conditional store succeeded, 0 = failed |

## Verification
On every cycle the assertions check the following:
- plain stores are always granted;
- the grant of a conditional store equals its status;
- an idle strobe produces no outputs;
- no context ever owns two slots;
- a conditional store right after a same-context load-reserve to the same granule succeeds;
- one right after any write to its granule, or right after reset, fails.

Longer histories can only be shown by the bench's scenarios and its cycle-by-cycle reference model. These include moving a reservation, eviction of slot 0 from a full table, reads leaving reservations intact, and shared granules.

// File: rtl/resv_pkg.sv
package resv_pkg;

   typedef enum logic [1:0] {
      OP_READ      = 2'd0,
      OP_LOAD_RESV = 2'd1,
      OP_STORE     = 2'd2,
      OP_STORE_CND = 2'd3
   } resv_op_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/resv_match.sv
// Per-slot comparators: granule hit and owner hit for the current request.
module resv_match #(
   parameter int unsigned ENTRIES = 4,
   parameter int unsigned CTX_W   = 3,
   parameter int unsigned TAG_W   = 29
) (
   input  logic [ENTRIES-1:0]            slot_vld,
   input  logic [ENTRIES-1:0][CTX_W-1:0] slot_ctx,
   input  logic [ENTRIES-1:0][TAG_W-1:0] slot_tag,
   input  logic [CTX_W-1:0]              req_ctx,
   input  logic [TAG_W-1:0]              req_tag,
   output logic [ENTRIES-1:0]            tag_hit,
   output logic [ENTRIES-1:0]            own_hit,
   output logic                          pair_hit
);

   logic [ENTRIES-1:0] both;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign tag_hit[g] = slot_vld[g] && (slot_tag[g] == req_tag);
      assign own_hit[g] = slot_vld[g] && (slot_ctx[g] == req_ctx);
      assign both[g]    = tag_hit[g] && own_hit[g];
   end

   assign pair_hit = |both;

endmodule

// File: rtl/resv_alloc.sv
// Slot choice for a load-reserve: own slot, else lowest free, else slot 0.
module resv_alloc #(
   parameter int unsigned ENTRIES = 4,
   parameter int unsigned IDX_W   = 2
) (
   input  logic [ENTRIES-1:0] slot_vld,
   input  logic [ENTRIES-1:0] own_hit,
   output logic [IDX_W-1:0]   pick_idx
);

   logic [IDX_W-1:0] own_idx;
   logic [IDX_W-1:0] free_idx;
   logic             own_any;
   logic             free_any;

   always_comb begin
      own_idx  = '0;
      own_any  = 1'b0;
      free_idx = '0;
      free_any = 1'b0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (own_hit[i]) begin
            own_idx = IDX_W'(i);
            own_any = 1'b1;
         end
         if (!slot_vld[i]) begin
            free_idx = IDX_W'(i);
            free_any = 1'b1;
         end
      end
   end

   always_comb begin
      if (own_any)       pick_idx = own_idx;
      else if (free_any) pick_idx = free_idx;
      else               pick_idx = '0;
   end

endmodule

// File: rtl/resv_table.sv
// Reservation storage: set one slot or clear a mask of slots per cycle.
module resv_table #(
   parameter int unsigned ENTRIES = 4,
   parameter int unsigned CTX_W   = 3,
   parameter int unsigned TAG_W   = 29,
   parameter int unsigned IDX_W   = 2
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          set_en,
   input  logic [IDX_W-1:0]              set_idx,
   input  logic [CTX_W-1:0]              set_ctx,
   input  logic [TAG_W-1:0]              set_tag,
   input  logic [ENTRIES-1:0]            clr_mask,
   output logic [ENTRIES-1:0]            slot_vld,
   output logic [ENTRIES-1:0][CTX_W-1:0] slot_ctx,
   output logic [ENTRIES-1:0][TAG_W-1:0] slot_tag
);

   for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      logic hit_set;
      assign hit_set = set_en && (set_idx == IDX_W'(g));

      always_ff @(posedge clk) begin
         if (rst) begin
            slot_vld[g] <= 1'b0;
         end else if (hit_set) begin
            slot_vld[g] <= 1'b1;
         end else if (clr_mask[g]) begin
            slot_vld[g] <= 1'b0;
         end
      end

      always_ff @(posedge clk) begin
         if (rst) begin
            slot_ctx[g] <= '0;
            slot_tag[g] <= '0;
         end else if (hit_set) begin
            slot_ctx[g] <= set_ctx;
            slot_tag[g] <= set_tag;
         end
      end
   end

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor #(
   parameter int unsigned ENTRIES = 4,
   parameter int unsigned CPU_W   = 2,
   parameter int unsigned THR_W   = 1,
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned GRAN_LG = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [CPU_W-1:0]  req_cpu,
   input  logic [THR_W-1:0]  req_thr,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              wr_grant,
   output logic              sc_valid,
   output logic              sc_status
);
   import resv_pkg::*;

   localparam int unsigned CTX_W = CPU_W + THR_W;
   localparam int unsigned TAG_W = ADDR_W - GRAN_LG;
   localparam int unsigned IDX_W = idx_width(ENTRIES);

   if (ENTRIES < 1) begin : g_bad_entries
      $error("resv_monitor: ENTRIES must be at least 1");
   end
   if (GRAN_LG >= ADDR_W) begin : g_bad_gran
      $error("resv_monitor: GRAN_LG must be below ADDR_W");
   end
   if (CPU_W < 1 || THR_W < 1) begin : g_bad_ctx
      $error("resv_monitor: context fields need at least one bit");
   end

   logic [CTX_W-1:0]              ctx;
   logic [TAG_W-1:0]              tag;
   resv_op_e                      op;
   logic                          is_lr, is_st, is_sc, is_wr;
   logic [ENTRIES-1:0]            slot_vld;
   logic [ENTRIES-1:0][CTX_W-1:0] slot_ctx;
   logic [ENTRIES-1:0][TAG_W-1:0] slot_tag;
   logic [ENTRIES-1:0]            tag_hit;
   logic [ENTRIES-1:0]            own_vec;
   logic                          pair_hit;
   logic [IDX_W-1:0]              pick_idx;

   assign ctx   = {req_cpu, req_thr};
   assign tag   = req_addr[ADDR_W-1:GRAN_LG];
   assign op    = resv_op_e'(req_op);
   assign is_lr = req_valid && (op == OP_LOAD_RESV);
   assign is_st = req_valid && (op == OP_STORE);
   assign is_sc = req_valid && (op == OP_STORE_CND);
   assign is_wr = is_st || is_sc;

   resv_match #(.ENTRIES(ENTRIES), .CTX_W(CTX_W), .TAG_W(TAG_W)) match_i (
      .slot_vld (slot_vld),
      .slot_ctx (slot_ctx),
      .slot_tag (slot_tag),
      .req_ctx  (ctx),
      .req_tag  (tag),
      .tag_hit  (tag_hit),
      .own_hit  (own_vec),
      .pair_hit (pair_hit)
   );

   resv_alloc #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) alloc_i (
      .slot_vld (slot_vld),
      .own_hit  (own_vec),
      .pick_idx (pick_idx)
   );

   resv_table #(.ENTRIES(ENTRIES), .CTX_W(CTX_W), .TAG_W(TAG_W), .IDX_W(IDX_W)) table_i (
      .clk      (clk),
      .rst      (rst),
      .set_en   (is_lr),
      .set_idx  (pick_idx),
      .set_ctx  (ctx),
      .set_tag  (tag),
      .clr_mask (is_wr ? tag_hit : '0),
      .slot_vld (slot_vld),
      .slot_ctx (slot_ctx),
      .slot_tag (slot_tag)
   );

   assign wr_grant  = is_st || (is_sc && pair_hit);
   assign sc_valid  = is_sc;
   assign sc_status = is_sc && pair_hit;

endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
   parameter int unsigned ENTRIES = 4,
   parameter int unsigned CPU_W   = 2,
   parameter int unsigned THR_W   = 1,
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned GRAN_LG = 3
) (
   input logic              clk,
   input logic              rst,
   input logic              req_valid,
   input logic [1:0]        req_op,
   input logic [CPU_W-1:0]  req_cpu,
   input logic [THR_W-1:0]  req_thr,
   input logic [ADDR_W-1:0] req_addr,
   input logic              wr_grant,
   input logic              sc_valid,
   input logic              sc_status,
   input logic [ENTRIES-1:0] own_vec
);
   localparam int unsigned CTX_W = CPU_W + THR_W;
   localparam int unsigned TAG_W = ADDR_W - GRAN_LG;

   logic [TAG_W-1:0] tag, prev_tag;
   logic [CTX_W-1:0] ctx, prev_ctx;
   logic             prev_wr, prev_lr, prev_rst;
   logic             now_sc;

   assign tag    = req_addr[ADDR_W-1:GRAN_LG];
   assign ctx    = {req_cpu, req_thr};
   assign now_sc = req_valid && (req_op == 2'd3);

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_wr  <= 1'b0;
         prev_lr  <= 1'b0;
         prev_rst <= 1'b1;
         prev_tag <= '0;
         prev_ctx <= '0;
      end else begin
         prev_wr  <= req_valid && req_op[1];
         prev_lr  <= req_valid && (req_op == 2'd1);
         prev_rst <= 1'b0;
         prev_tag <= tag;
         prev_ctx <= ctx;
      end
   end

   a_r6_store_granted: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_op == 2'd2) |-> wr_grant);

   a_r7_grant_tracks_status: assert property (@(posedge clk) disable iff (rst)
      now_sc |-> (wr_grant == sc_status));

   a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      !req_valid |-> (!wr_grant && !sc_valid && !sc_status));

   a_r8_status_needs_valid: assert property (@(posedge clk) disable iff (rst)
      sc_status |-> sc_valid);

   a_r3_one_slot_per_ctx: assert property (@(posedge clk) disable iff (rst)
      $onehot0(own_vec));

   a_r10_lr_then_sc: assert property (@(posedge clk) disable iff (rst)
      (now_sc && prev_lr && prev_ctx == ctx && prev_tag == tag) |-> sc_status);

   a_r5_write_clears: assert property (@(posedge clk) disable iff (rst)
      (now_sc && prev_wr && prev_tag == tag) |-> !sc_status);

   a_r11_reset_empty: assert property (@(posedge clk) disable iff (rst)
      (now_sc && prev_rst) |-> !sc_status);

endmodule

bind resv_monitor resv_monitor_chk #(
   .ENTRIES(ENTRIES), .CPU_W(CPU_W), .THR_W(THR_W), .ADDR_W(ADDR_W), .GRAN_LG(GRAN_LG)
) chk_i (
   .clk       (clk),
   .rst       (rst),
   .req_valid (req_valid),
   .req_op    (req_op),
   .req_cpu   (req_cpu),
   .req_thr   (req_thr),
   .req_addr  (req_addr),
   .wr_grant  (wr_grant),
   .sc_valid  (sc_valid),
   .sc_status (sc_status),
   .own_vec   (own_vec)
);

// File: tb/resv_monitor_tb_top.sv
`timescale 1ns/1ps
module resv_monitor_tb_top;
   localparam int ENTRIES = 4;
   localparam int CPU_W   = 2;
   localparam int THR_W   = 1;
   localparam int ADDR_W  = 32;
   localparam int GRAN_LG = 3;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              req_valid = 1'b0;
   logic [1:0]        req_op = 2'd0;
   logic [CPU_W-1:0]  req_cpu = '0;
   logic [THR_W-1:0]  req_thr = '0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic              wr_grant, sc_valid, sc_status;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   // reference model: slot arrays, plain integers
   bit m_vld [ENTRIES];
   int m_ctx [ENTRIES];
   longint m_gran [ENTRIES];

   always #5 clk = ~clk;

   resv_monitor #(.ENTRIES(ENTRIES), .CPU_W(CPU_W), .THR_W(THR_W),
                  .ADDR_W(ADDR_W), .GRAN_LG(GRAN_LG)) dut_i (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
      .req_cpu(req_cpu), .req_thr(req_thr), .req_addr(req_addr),
      .wr_grant(wr_grant), .sc_valid(sc_valid), .sc_status(sc_status));

   function automatic void model_clear();
      for (int i = 0; i < ENTRIES; i++) m_vld[i] = 0;
   endfunction

   task automatic chk(input string tag, input string what, input logic got, input logic exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s %s got=%0b exp=%0b at %0t", tag, what, got, exp, $time);
      end
   endtask

   task automatic do_reset(input int n);
      @(negedge clk);
      rst = 1'b1; req_valid = 1'b0;
      repeat (n) @(negedge clk);
      rst = 1'b0;
      model_clear();
   endtask

   task automatic step(input bit v, input int op, input int cpu, input int thr,
                       input longint addr, input string tag);
      int c;
      longint gr;
      bit pair;
      int pick;
      @(negedge clk);
      req_valid = v; req_op = op[1:0]; req_cpu = cpu[CPU_W-1:0];
      req_thr = thr[THR_W-1:0]; req_addr = addr[ADDR_W-1:0];
      c = cpu * (1 << THR_W) + thr;
      gr = addr >> GRAN_LG;
      pair = 0;
      for (int i = 0; i < ENTRIES; i++)
         if (m_vld[i] && m_ctx[i] == c && m_gran[i] == gr) pair = 1;
      #1;
      chk(tag, "wr_grant", wr_grant, v && (op == 2 || (op == 3 && pair)));
      chk(tag, "sc_valid", sc_valid, v && op == 3);
      chk(tag, "sc_status", sc_status, v && op == 3 && pair);
      if (v && op == 1) begin
         pick = -1;
         for (int i = 0; i < ENTRIES; i++)
            if (pick < 0 && m_vld[i] && m_ctx[i] == c) pick = i;
         for (int i = 0; i < ENTRIES; i++)
            if (pick < 0 && !m_vld[i]) pick = i;
         if (pick < 0) pick = 0;
         m_vld[pick] = 1; m_ctx[pick] = c; m_gran[pick] = gr;
      end else if (v && op >= 2) begin
         for (int i = 0; i < ENTRIES; i++)
            if (m_vld[i] && m_gran[i] == gr) m_vld[i] = 0;
      end
   endtask

   initial begin
      #(10 * 200000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      do_reset(3);
      // R12 idle after reset
      step(0, 3, 0, 0, 'h100, "R12");
      // R11 nothing reserved after reset
      step(1, 3, 0, 0, 'h100, "R11");
      // R10 / R2 reserve then SC in next cycle, same granule
      step(1, 1, 0, 0, 'h100, "R10");
      step(1, 3, 0, 0, 'h104, "R2");
      // R2 different granule fails
      step(1, 1, 1, 0, 'h700, "R2");
      step(1, 3, 1, 0, 'h708, "R2");
      // R3 move reservation
      step(1, 1, 1, 1, 'h200, "R3");
      step(1, 1, 1, 1, 'h300, "R3");
      step(1, 3, 1, 1, 'h200, "R3");
      step(1, 3, 1, 1, 'h300, "R3");
      // R4 / R5 shared granule, write clears both
      step(1, 1, 2, 0, 'h400, "R4");
      step(1, 1, 3, 0, 'h400, "R4");
      step(1, 3, 3, 0, 'h400, "R4");
      step(1, 3, 2, 0, 'h400, "R5");
      // R1 read leaves reservation
      step(1, 1, 0, 1, 'h500, "R1");
      step(1, 0, 2, 1, 'h500, "R1");
      step(1, 0, 0, 1, 'h500, "R1");
      step(1, 3, 0, 1, 'h500, "R1");
      // R6 plain store granted, then R5 clears other context
      step(1, 1, 0, 0, 'h600, "R6");
      step(1, 2, 3, 1, 'h600, "R6");
      step(1, 3, 0, 0, 'h600, "R5");
      // R7 SC by other context on reserved granule fails
      step(1, 1, 1, 0, 'h900, "R7");
      step(1, 3, 2, 1, 'h900, "R7");
      // R9 eviction of slot 0
      do_reset(1);
      for (int k = 0; k < ENTRIES + 1; k++)
         step(1, 1, k / 2, k % 2, 'h1000 + k * 'h40, "R9");
      step(1, 3, 0, 0, 'h1000, "R9");
      step(1, 3, 2, 0, 'h1000 + 4 * 'h40, "R9");
      step(1, 3, 0, 1, 'h1040, "R9");
      // R11 mid-run reset
      step(1, 1, 2, 1, 'h800, "R11");
      do_reset(1);
      step(1, 3, 2, 1, 'h800, "R11");
      // R12 idle does not disturb table
      step(1, 1, 3, 1, 'hA00, "R12");
      step(0, 2, 0, 0, 'hA00, "R12");
      step(1, 3, 3, 1, 'hA00, "R12");
      // random mix against the model
      for (int k = 0; k < 3000; k++)
         step($urandom_range(0, 7) != 0, $urandom_range(0, 3), $urandom_range(0, 3),
              $urandom_range(0, 1), 'h2000 + $urandom_range(0, 5) * 8 + $urandom_range(0, 7),
              "R5/R7 random");
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule